// File: doc/BRIEF.md
# Expansion Slot Error Fence

This block sits between the host's access port and one downstream expansion slot. It also sits between that slot's inbound DMA port and system memory. It forwards traffic in both directions while the slot behaves. When it sees an error, it fences the slot off. The errors it watches for are:

- an inbound DMA access that falls outside a programmable window of reserved memory;
- a data parity strobe;
- an address parity strobe;
- a split-completion error strobe.

While the slot is fenced, no write reaches either side. Every read returns all-ones at the access width, which is what an empty slot would return. Interrupt lines from the slot are still passed through. The host reads a status register to tell a real fence from a device that legitimately returned all-ones. It pulses a clear input to release the fence once the slot has been recovered.

Detection must be switched on before the slot is used. While the enable input is low, every access is fenced in the same way, and error strobes are not recorded.

Top module: `slot_fence`

## Requirements
- R1: After reset the block is not frozen and the cause field is zero. The window base reads all-ones and the window limit reads zero, so the window is empty.
- R2: With detection enabled and the block not frozen, a DMA access is forwarded (`mem_req` high in the same cycle) exactly when base <= address <= limit. If limit < base, no DMA address is inside the window.
- R3: A DMA access outside the window sets the frozen flag on the next clock edge and sets cause bit 0. The offending access itself is not forwarded.
- R4: Error strobes set the frozen flag on the next edge. A data parity strobe sets cause bit 1, an address parity strobe sets cause bit 2, and a split-completion strobe sets cause bit 3. Any access in the same cycle as a strobe is fenced.
- R5: While frozen, host accesses do not reach the slot (`slot_req` low), whether they are reads or writes. DMA accesses do not reach memory (`mem_req` low).
- R6: While frozen, a host read returns 0xFF for size code 0, 0xFFFF for size code 1 and 0xFFFFFFFF for size codes 2 and 3. This holds for space codes 0 (memory), 1 (I/O) and 2 (configuration) alike. A DMA read returns all-ones.
- R7: `irq_out` follows `irq_in` in the same cycle whether or not the slot is frozen.
- R8: While `det_en` is low, accesses are fenced as in R5 and R6. Error strobes and out-of-window DMA do not set the frozen flag.
- R9: The frozen flag stays set until `clr` is pulsed. A clear resets the flag and the cause field. Errors that arrive while frozen OR their bits into the cause field.
- R10: Register select 0 reads and writes the window base, and select 1 the window limit. Select 2 reads status, with the frozen flag at bit 4 and the cause at bits 3:0. Writes to selects 2 and 3 change nothing.
- R11: If an error arrives in the same cycle as `clr`, the block stays frozen. The cause field then holds only the new error's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Error detection enable |
| clr | input | 1 | Release strobe for the fence |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_space | input | 2 | Address space code |
| host_size | input | 2 | Access size code |
| host_addr | input | AW | Host access address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| slot_req | output | 1 | Request forwarded to the slot |
| slot_we | output | 1 | Forwarded write flag |
| slot_space | output | 2 | Forwarded space code |
| slot_size | output | 2 | Forwarded size code |
| slot_addr | output | AW | Forwarded address |
| slot_wdata | output | DW | Forwarded write data |
| slot_rdata | input | DW | Read data from the slot |
| dma_req | input | 1 | Inbound DMA request |
| dma_we | input | 1 | DMA is a write |
| dma_addr | input | AW | DMA address |
| dma_wdata | input | DW | DMA write data |
| dma_rdata | output | DW | DMA read data |
| mem_req | output | 1 | DMA request forwarded to memory |
| mem_we | output | 1 | Forwarded DMA write flag |
| mem_addr | output | AW | Forwarded DMA address |
| mem_wdata | output | DW | Forwarded DMA write data |
| mem_rdata | input | DW | Read data from memory |
| perr_data | input | 1 | Data parity error strobe |
| perr_addr | input | 1 | Address parity error strobe |
| split_err | input | 1 | Split-completion error strobe |
| irq_in | input | 1 | Interrupt from the slot |
| irq_out | output | 1 | Interrupt to the host |

## Verification
The assertions assume that the error strobes and `dma_req` are single-cycle, synchronous pulses. They assume that the window registers only change while no DMA is in flight. They also assume that `clr` is not held across a new error, since R11 makes that case re-freeze. The stimulus drives every input on the falling edge. It changes base and limit only with `dma_req` low, and raises each strobe for exactly one cycle. It pulses `clr` for one cycle between vectors, so that each case starts from an unfrozen state.

// File: rtl/slot_fence.sv
module slot_fence #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_en,
  input  logic          clr,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_space,
  input  logic [1:0]    host_size,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          slot_req,
  output logic          slot_we,
  output logic [1:0]    slot_space,
  output logic [1:0]    slot_size,
  output logic [AW-1:0] slot_addr,
  output logic [DW-1:0] slot_wdata,
  input  logic [DW-1:0] slot_rdata,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] dma_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          perr_data,
  input  logic          perr_addr,
  input  logic          split_err,
  input  logic          irq_in,
  output logic          irq_out
);
  localparam int NCAUSE = 4;

  logic [AW-1:0]     base_q, limit_q;
  logic              frozen_q;
  logic [NCAUSE-1:0] cause_q;
  logic              in_win, fence;
  logic [NCAUSE-1:0] err_ev;
  logic [DW-1:0]     ones_w;

  assign in_win = (base_q <= limit_q) && (dma_addr >= base_q) && (dma_addr <= limit_q);
  assign err_ev = {split_err, perr_addr, perr_data, dma_req & ~in_win} & {NCAUSE{det_en}};
  assign fence  = ~det_en | frozen_q | (|err_ev);

  always_comb begin
    ones_w = '1;
    if (host_size == 2'd0) ones_w = DW'(8'hFF);
    else if (host_size == 2'd1) ones_w = DW'(16'hFFFF);
  end

  assign slot_req   = host_req & ~fence;
  assign slot_we    = host_we;
  assign slot_space = host_space;
  assign slot_size  = host_size;
  assign slot_addr  = host_addr;
  assign slot_wdata = host_wdata;
  assign host_rdata = fence ? ones_w : slot_rdata;

  assign mem_req   = dma_req & ~fence;
  assign mem_we    = dma_we;
  assign mem_addr  = dma_addr;
  assign mem_wdata = dma_wdata;
  assign dma_rdata = fence ? '1 : mem_rdata;

  assign irq_out = irq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '1;
      limit_q  <= '0;
      frozen_q <= 1'b0;
      cause_q  <= '0;
    end else begin
      if (cfg_we && cfg_sel == 2'd0) base_q  <= cfg_wdata;
      if (cfg_we && cfg_sel == 2'd1) limit_q <= cfg_wdata;
      if (|err_ev) begin
        frozen_q <= 1'b1;
        cause_q  <= (clr ? '0 : cause_q) | err_ev;
      end else if (clr) begin
        frozen_q <= 1'b0;
        cause_q  <= '0;
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = base_q;
      2'd1:    cfg_rdata = limit_q;
      2'd2:    cfg_rdata = AW'({frozen_q, cause_q});
      default: cfg_rdata = '0;
    endcase
  end

  // R2
  dma_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (dma_addr >= base_q && dma_addr <= limit_q));

  // R3
  dma_escape_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && dma_req && !mem_req && !(dma_addr >= base_q && dma_addr <= limit_q)) |=> (frozen_q && cause_q[0]));

  // R4
  parity_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && perr_data) |=> (frozen_q && cause_q[1]));

  // R5
  frozen_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (!slot_req && !mem_req));

  // R9
  freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !clr) |=> (frozen_q && ((cause_q & $past(cause_q)) == $past(cause_q))));

  // R8
  disabled_no_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !frozen_q) |=> !frozen_q);
endmodule

// File: tb/slot_fence_bench.sv
module slot_fence_bench;
  logic clk = 0, rst_n = 0, det_en = 0, clr = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic host_req = 0, host_we = 0;
  logic [1:0] host_space = 0, host_size = 0;
  logic [31:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic slot_req, slot_we;
  logic [1:0] slot_space, slot_size;
  logic [31:0] slot_addr, slot_wdata, slot_rdata = 32'h1234_5678;
  logic dma_req = 0, dma_we = 0;
  logic [31:0] dma_addr = 0, dma_wdata = 0, dma_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0BAD_F00D;
  logic perr_data = 0, perr_addr = 0, split_err = 0, irq_in = 0, irq_out;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  slot_fence u_slot_fence (.*);

  localparam int NV = 6;
  localparam logic [96:0] VEC [NV] = '{
    {32'h1000, 32'h1FFF, 32'h1000, 1'b1},
    {32'h1000, 32'h1FFF, 32'h1FFF, 1'b1},
    {32'h1000, 32'h1FFF, 32'h0FFF, 1'b0},
    {32'h1000, 32'h1FFF, 32'h2000, 1'b0},
    {32'h2000, 32'h1000, 32'h1800, 1'b0},
    {32'h4000, 32'h4000, 32'h4000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic status(input string req, input logic [31:0] exp);
    cfg_sel = 2; #1; check(req, cfg_rdata, exp);
  endtask

  task automatic release_fence;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #500000;
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    #12; rst_n = 1;
    @(negedge clk);
    status("R1 status", 32'h0);
    cfg_sel = 0; #1; check("R1 base", cfg_rdata, 32'hFFFF_FFFF);
    cfg_sel = 1; #1; check("R1 limit", cfg_rdata, 32'h0);

    perr_data = 1; dma_req = 1; dma_addr = 32'h10;
    @(negedge clk); perr_data = 0; dma_req = 0;
    status("R8 no freeze while disabled", 32'h0);
    host_req = 1; host_size = 2; #1;
    check("R8 slot_req", {31'b0, slot_req}, 0);
    check("R8 read ones", host_rdata, 32'hFFFF_FFFF);
    host_req = 0;

    det_en = 1;
    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][96:65]); wr(1, VEC[i][64:33]);
      @(negedge clk); dma_req = 1; dma_we = 1; dma_addr = VEC[i][32:1]; #1;
      check("R2 R3 forward", {31'b0, mem_req}, {31'b0, VEC[i][0]});
      @(negedge clk); dma_req = 0; dma_we = 0;
      status("R3 freeze", VEC[i][0] ? 32'h0 : 32'h11);
      release_fence();
    end

    wr(0, 32'h1000); wr(1, 32'h1FFF);
    @(negedge clk); perr_addr = 1; host_req = 1; host_we = 1; #1;
    check("R4 same-cycle fence", {31'b0, slot_req}, 0);
    @(negedge clk); perr_addr = 0; host_req = 0; host_we = 0;
    status("R4 addr parity", 32'h14);
    split_err = 1;
    @(negedge clk); split_err = 0;
    status("R9 OR-in", 32'h1C);
    perr_data = 1;
    @(negedge clk); perr_data = 0;
    status("R9 OR-in data", 32'h1E);
    repeat (3) @(negedge clk);
    status("R9 holds", 32'h1E);

    host_req = 1; host_we = 1; dma_req = 1; dma_we = 1; dma_addr = 32'h1800; #1;
    check("R5 host write blocked", {31'b0, slot_req}, 0);
    check("R5 dma write blocked", {31'b0, mem_req}, 0);
    host_we = 0; dma_we = 0;
    for (int sp = 0; sp < 3; sp++)
      for (int sz = 0; sz < 4; sz++) begin
        host_space = 2'(sp); host_size = 2'(sz); #1;
        check("R6 read ones", host_rdata,
              sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF);
      end
    check("R6 dma read ones", dma_rdata, 32'hFFFF_FFFF);
    irq_in = 1; #1; check("R7 irq while frozen", {31'b0, irq_out}, 1);
    irq_in = 0; #1; check("R7 irq low", {31'b0, irq_out}, 0);
    host_req = 0; dma_req = 0;

    wr(2, 32'h0); wr(3, 32'h0);
    status("R10 status not writable", 32'h1E);

    release_fence();
    status("R9 cleared", 32'h0);
    host_req = 1; host_size = 2; #1;
    check("R5 unfrozen forward", {31'b0, slot_req}, 1);
    check("R6 unfrozen data", host_rdata, 32'h1234_5678);
    host_req = 0;
    cfg_sel = 0; #1; check("R10 base readback", cfg_rdata, 32'h1000);

    perr_data = 1;
    @(negedge clk); perr_data = 0;
    clr = 1; split_err = 1;
    @(negedge clk); clr = 0; split_err = 0;
    status("R11 error beats clear", 32'h18);
    release_fence();
    status("R11 then clear", 32'h0);

    finish_up();
  end
endmodule